// File: doc/BRIEF.md
# Write-Through No-Allocate Data Cache Front

This block is a small first-level data cache that never holds modified data. A processor issues single-word reads and writes on a request port. Reads that find their line resident come back from local storage. Reads that miss fetch a whole 64-byte line from the next level, one word per beat, and then answer. Because the next level always has the current copy, there is no dirty state and an evicted line is simply overwritten.

Every processor write is posted into a small FIFO and drained to the next level as a single word write. The processor does not wait for that write unless the FIFO is full. A write that hits also updates the cached word in the cycle it is accepted. A write that misses leaves the cache as it was. A read miss first compares its line against every pending write. If any of them match, the fill waits until those writes have drained, so the fill never returns stale data.

Top module: `wt_dcache_front`

## Requirements
- R1: After reset the request port is ready, and no response, line request or downstream write is pending.
- R2: A read that hits returns the current word one cycle after acceptance, with no line request.
- R3: A read miss makes exactly one line request at the address with bits [5:0] cleared, held stable until taken. It then takes 16 beats in word order starting at word 0 and answers with the requested word. Later reads anywhere in that line hit.
- R4: Every accepted write appears exactly once on the downstream write port, in acceptance order, with its address bits [1:0] cleared and its data unchanged. Address and data are held while the port stalls.
- R5: A write that hits updates the cached word, so a following read hits and returns the new value.
- R6: A write that misses causes no line request and changes no cached line. A later read of that line misses and returns the written value.
- R7: The write buffer holds 4 entries. With 4 writes pending, a further write is not accepted, while reads are still accepted.
- R8: A read miss whose line matches a pending buffered write raises no line request until that write has left the buffer.
- R9: A read miss whose line matches no pending write is served while the downstream write port stays stalled.
- R10: The number of downstream writes equals the number of accepted writes, including across line replacements; there is no write-back.
- R11: The cache is direct-mapped with 16 lines indexed by address bits [9:6]. Addresses that differ only above bit 9 evict each other, while lines with different indices stay resident together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Processor request valid |
| req_ready_o | output | 1 | Request accepted this cycle when valid |
| req_write_i | input | 1 | 1 for a write, 0 for a read |
| req_addr_i | input | 32 | Byte address of the request |
| req_wdata_i | input | 32 | Write data |
| resp_valid_o | output | 1 | Read response valid (one cycle) |
| resp_rdata_o | output | 32 | Read response data |
| fill_req_valid_o | output | 1 | Line request valid |
| fill_req_ready_i | input | 1 | Line request taken |
| fill_req_addr_o | output | 32 | Line-aligned address of the requested line |
| fill_beat_valid_i | input | 1 | Fill data beat valid |
| fill_beat_data_i | input | 32 | Fill data beat, word 0 first |
| wr_valid_o | output | 1 | Downstream word write valid |
| wr_ready_i | input | 1 | Downstream word write taken |
| wr_addr_o | output | 32 | Word-aligned downstream write address |
| wr_data_o | output | 32 | Downstream write data |

## Verification
A wrong tag or valid bit shows up on the very next read of the affected line. A spurious hit returns a word that differs from the last value written, and a spurious miss raises a line request that the bench counts. A missed update on a store hit returns stale data one cycle after the following read is accepted. A broken line match in the write buffer lets a fill read the next level before the buffered word lands, so the response carries the old value. A FIFO pointer or count fault shows at the downstream write port as a write that is lost, repeated or out of order, on the first drain after the fault.

// File: rtl/wt_dcache_pkg.sv
package wt_dcache_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DRAIN,
    S_FILL_REQ,
    S_FILL_DATA,
    S_DONE
  } fe_state_e;

endpackage

// File: rtl/wt_dcache_lines.sv
module wt_dcache_lines #(
  parameter int NUM_LINES = 16,
  parameter int WORDS     = 16,
  parameter int DATA_W    = 32,
  parameter int TAG_W     = 22,
  parameter int IDX_W     = $clog2(NUM_LINES),
  parameter int OFF_W     = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [OFF_W-1:0]  rd_off_i,
  output logic              rd_valid_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [OFF_W-1:0]  wr_off_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              inval_i,
  input  logic              set_i,
  input  logic [TAG_W-1:0]  set_tag_i
);

  localparam int ENTRIES = NUM_LINES * WORDS;

  logic [NUM_LINES-1:0] valid_q;
  logic [TAG_W-1:0]     tag_q [NUM_LINES];
  logic [DATA_W-1:0]    mem_q [ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      for (int i = 0; i < NUM_LINES; i++) tag_q[i] <= '0;
    end else if (inval_i) begin
      valid_q[idx_i] <= 1'b0;
    end else if (set_i) begin
      valid_q[idx_i] <= 1'b1;
      tag_q[idx_i]   <= set_tag_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[{idx_i, wr_off_i}] <= wr_data_i;
  end

  assign rd_valid_o = valid_q[idx_i];
  assign rd_tag_o   = tag_q[idx_i];
  assign rd_data_o  = mem_q[{idx_i, rd_off_i}];

endmodule

// File: rtl/wt_dcache_wbuf.sv
module wt_dcache_wbuf #(
  parameter int DEPTH      = 4,
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_OFF_W = 6
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         push_i,
  input  logic [ADDR_W-1:0]            push_addr_i,
  input  logic [DATA_W-1:0]            push_data_i,
  output logic                         full_o,
  output logic                         out_valid_o,
  input  logic                         out_ready_i,
  output logic [ADDR_W-1:0]            out_addr_o,
  output logic [DATA_W-1:0]            out_data_o,
  input  logic [ADDR_W-LINE_OFF_W-1:0] match_line_i,
  output logic                         match_o
);

  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LINE_W = ADDR_W - LINE_OFF_W;

  logic [ADDR_W-1:0] slot_addr [DEPTH];
  logic [DATA_W-1:0] slot_data [DEPTH];
  logic [DEPTH-1:0]  slot_vld;
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [PTR_W:0]    count_q;
  logic [DEPTH-1:0]  hit_vec;
  logic              pop;

  assign full_o      = count_q == (PTR_W+1)'(DEPTH);
  assign out_valid_o = count_q != '0;
  assign pop         = out_valid_o && out_ready_i;
  assign out_addr_o  = slot_addr[rd_ptr_q];
  assign out_data_o  = slot_data[rd_ptr_q];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
      slot_vld <= '0;
    end else begin
      if (push_i) begin
        slot_vld[wr_ptr_q] <= 1'b1;
        wr_ptr_q           <= bump(wr_ptr_q);
      end
      if (pop) begin
        slot_vld[rd_ptr_q] <= 1'b0;
        rd_ptr_q           <= bump(rd_ptr_q);
      end
      if (push_i && !pop)      count_q <= count_q + 1'b1;
      else if (pop && !push_i) count_q <= count_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      slot_addr[wr_ptr_q] <= push_addr_i;
      slot_data[wr_ptr_q] <= push_data_i;
    end
  end

  // line compare against every live slot
  for (genvar g = 0; g < DEPTH; g++) begin : g_match
    assign hit_vec[g] = slot_vld[g] &&
                        (slot_addr[g][ADDR_W-1 -: LINE_W] == match_line_i);
  end
  assign match_o = |hit_vec;

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);

  p_occupancy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(slot_vld) == int'(count_q));

  p_wr_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_addr_o) && $stable(out_data_o)));

endmodule

// File: rtl/wt_dcache_front.sv
module wt_dcache_front
  import wt_dcache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int NUM_LINES  = 16,
  parameter int WB_DEPTH   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              resp_valid_o,
  output logic [DATA_W-1:0] resp_rdata_o,
  output logic              fill_req_valid_o,
  input  logic              fill_req_ready_i,
  output logic [ADDR_W-1:0] fill_req_addr_o,
  input  logic              fill_beat_valid_i,
  input  logic [DATA_W-1:0] fill_beat_data_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);

  localparam int WORD_BYTES = DATA_W / 8;
  localparam int BYTE_OFF_W = $clog2(WORD_BYTES);
  localparam int WORDS      = LINE_BYTES / WORD_BYTES;
  localparam int WOFF_W     = $clog2(WORDS);
  localparam int LINE_OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W      = $clog2(NUM_LINES);
  localparam int TAG_W      = ADDR_W - LINE_OFF_W - IDX_W;
  localparam int LINE_W     = ADDR_W - LINE_OFF_W;

  fe_state_e state_q, state_d;

  logic [ADDR_W-1:0] miss_addr_q;
  logic [WOFF_W-1:0] beat_q;
  logic              resp_valid_q;
  logic [DATA_W-1:0] resp_data_q;

  logic [ADDR_W-1:0] lk_addr;
  logic [IDX_W-1:0]  lk_idx;
  logic [WOFF_W-1:0] lk_off;
  logic [TAG_W-1:0]  lk_tag;
  logic [LINE_W-1:0] lk_line;

  logic              ls_valid;
  logic [TAG_W-1:0]  ls_tag;
  logic [DATA_W-1:0] ls_data;
  logic              hit;

  logic              wb_full, wb_match;
  logic              acc, acc_rd, acc_wr, st_hit;
  logic              fill_wr, last_beat, fill_take;
  logic              ls_wr_en;
  logic [WOFF_W-1:0] ls_wr_off;
  logic [DATA_W-1:0] ls_wr_data;
  logic [ADDR_W-1:0] push_addr;
  logic              unused_lk;

  // lookup address: live request when idle, held miss address otherwise
  assign lk_addr   = (state_q == S_IDLE) ? req_addr_i : miss_addr_q;
  assign lk_idx    = lk_addr[LINE_OFF_W +: IDX_W];
  assign lk_off    = lk_addr[BYTE_OFF_W +: WOFF_W];
  assign lk_tag    = lk_addr[ADDR_W-1 -: TAG_W];
  assign lk_line   = lk_addr[ADDR_W-1 -: LINE_W];
  assign unused_lk = ^lk_addr[BYTE_OFF_W-1:0];

  assign hit = ls_valid && (ls_tag == lk_tag);

  assign req_ready_o = (state_q == S_IDLE) && !(req_write_i && wb_full);
  assign acc         = req_valid_i && req_ready_o;
  assign acc_rd      = acc && !req_write_i;
  assign acc_wr      = acc && req_write_i;
  assign st_hit      = acc_wr && hit;
  assign push_addr   = {req_addr_i[ADDR_W-1:BYTE_OFF_W], {BYTE_OFF_W{1'b0}}};

  assign fill_take = (state_q == S_FILL_REQ) && fill_req_ready_i;
  assign fill_wr   = (state_q == S_FILL_DATA) && fill_beat_valid_i;
  assign last_beat = fill_wr && (beat_q == WOFF_W'(WORDS-1));

  assign ls_wr_en   = fill_wr || st_hit;
  assign ls_wr_off  = fill_wr ? beat_q : lk_off;
  assign ls_wr_data = fill_wr ? fill_beat_data_i : req_wdata_i;

  assign fill_req_valid_o = (state_q == S_FILL_REQ);
  assign fill_req_addr_o  = {miss_addr_q[ADDR_W-1:LINE_OFF_W], {LINE_OFF_W{1'b0}}};

  assign resp_valid_o = resp_valid_q;
  assign resp_rdata_o = resp_data_q;

  wt_dcache_lines #(
    .NUM_LINES (NUM_LINES),
    .WORDS     (WORDS),
    .DATA_W    (DATA_W),
    .TAG_W     (TAG_W)
  ) u_lines (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .idx_i      (lk_idx),
    .rd_off_i   (lk_off),
    .rd_valid_o (ls_valid),
    .rd_tag_o   (ls_tag),
    .rd_data_o  (ls_data),
    .wr_en_i    (ls_wr_en),
    .wr_off_i   (ls_wr_off),
    .wr_data_i  (ls_wr_data),
    .inval_i    (fill_take),
    .set_i      (last_beat),
    .set_tag_i  (lk_tag)
  );

  wt_dcache_wbuf #(
    .DEPTH      (WB_DEPTH),
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .LINE_OFF_W (LINE_OFF_W)
  ) u_wbuf (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_i       (acc_wr),
    .push_addr_i  (push_addr),
    .push_data_i  (req_wdata_i),
    .full_o       (wb_full),
    .out_valid_o  (wr_valid_o),
    .out_ready_i  (wr_ready_i),
    .out_addr_o   (wr_addr_o),
    .out_data_o   (wr_data_o),
    .match_line_i (lk_line),
    .match_o      (wb_match)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:      if (acc_rd && !hit) state_d = wb_match ? S_DRAIN : S_FILL_REQ;
      S_DRAIN:     if (!wb_match) state_d = S_FILL_REQ;
      S_FILL_REQ:  if (fill_req_ready_i) state_d = S_FILL_DATA;
      S_FILL_DATA: if (last_beat) state_d = S_DONE;
      S_DONE:      state_d = S_IDLE;
      default:     state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= S_IDLE;
      miss_addr_q  <= '0;
      beat_q       <= '0;
      resp_valid_q <= 1'b0;
      resp_data_q  <= '0;
    end else begin
      state_q      <= state_d;
      resp_valid_q <= 1'b0;
      if (acc_rd && !hit) miss_addr_q <= req_addr_i;
      if (fill_take) beat_q <= '0;
      else if (fill_wr) beat_q <= beat_q + 1'b1;
      // hit answers at once; a fill answers from the array once the line is in
      if ((acc_rd && hit) || state_q == S_DONE) begin
        resp_valid_q <= 1'b1;
        resp_data_q  <= ls_data;
      end
    end
  end

  p_fill_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_req_valid_o |-> !wb_match);

  p_fill_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_req_valid_o && !fill_req_ready_i) |=>
      (fill_req_valid_o && $stable(fill_req_addr_o)));

  p_busy_no_store_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != S_IDLE) |-> !acc_wr);

endmodule

// File: tb/wt_dcache_front_bench.sv
module wt_dcache_front_bench;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_WORDS  = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        req_ready, resp_valid;
  logic [31:0] resp_rdata;
  logic        fill_req_valid, fill_req_ready = 1'b0;
  logic [31:0] fill_req_addr;
  logic        fill_beat_valid = 1'b0;
  logic [31:0] fill_beat_data = '0;
  logic        wr_valid, wr_ready = 1'b0;
  logic [31:0] wr_addr, wr_data;

  int total = 0, bad = 0;
  int fill_cnt = 0, dwr_cnt = 0, stores = 0;
  logic [31:0] last_fill_addr = '0;
  logic        wr_stall = 1'b0;

  logic [31:0] arch   [MEM_WORDS];
  logic [31:0] nl_mem [MEM_WORDS];
  logic [63:0] exp_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  wt_dcache_front u_wt_dcache_front (
    .clk_i            (clk),
    .rst_ni           (rst_n),
    .req_valid_i      (req_valid),
    .req_ready_o      (req_ready),
    .req_write_i      (req_write),
    .req_addr_i       (req_addr),
    .req_wdata_i      (req_wdata),
    .resp_valid_o     (resp_valid),
    .resp_rdata_o     (resp_rdata),
    .fill_req_valid_o (fill_req_valid),
    .fill_req_ready_i (fill_req_ready),
    .fill_req_addr_o  (fill_req_addr),
    .fill_beat_valid_i(fill_beat_valid),
    .fill_beat_data_i (fill_beat_data),
    .wr_valid_o       (wr_valid),
    .wr_ready_i       (wr_ready),
    .wr_addr_o        (wr_addr),
    .wr_data_o        (wr_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // next-level model: acts at falling edges only
  initial begin
    logic        pend = 1'b0;
    logic [31:0] pa = '0, pd = '0;
    int          fst = 0, fbeat = 0;
    logic [31:0] fline = '0;
    logic [63:0] e;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        pend = 1'b0; fst = 0; wr_ready = 1'b0;
        fill_req_ready = 1'b0; fill_beat_valid = 1'b0;
      end else begin
        if (pend) begin
          dwr_cnt++;
          nl_mem[int'(pa[13:2])] = pd;
          if (exp_q.size() == 0) begin
            chk(1'b0, "R4", "unexpected downstream write", pa, 32'h0);
          end else begin
            e = exp_q.pop_front();
            chk(pa == e[63:32], "R4", "downstream addr", pa, e[63:32]);
            chk(pd == e[31:0],  "R4", "downstream data", pd, e[31:0]);
          end
        end
        if (wr_valid && !wr_stall) begin
          wr_ready = 1'b1; pend = 1'b1; pa = wr_addr; pd = wr_data;
        end else begin
          wr_ready = 1'b0; pend = 1'b0;
        end
        case (fst)
          0: if (fill_req_valid) begin
               fill_req_ready = 1'b1; fline = fill_req_addr;
               last_fill_addr = fill_req_addr; fill_cnt++; fst = 1;
             end
          1: begin
               fill_req_ready = 1'b0; fill_beat_valid = 1'b1;
               fill_beat_data = nl_mem[int'(fline[13:2])];
               fbeat = 1; fst = 2;
             end
          default: begin
               if (fbeat == 16) begin
                 fill_beat_valid = 1'b0; fst = 0;
               end else begin
                 fill_beat_data = nl_mem[int'(fline[13:2]) + fbeat];
                 fbeat++;
               end
             end
        endcase
      end
    end
  end

  task automatic do_read(input logic [31:0] a, output logic [31:0] got,
                         output int lat, output int fills);
    int  f0;
    logic rdy;
    f0 = fill_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    do begin
      #1 rdy = req_ready;
      @(posedge clk);
    end while (!rdy);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!resp_valid && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    got   = resp_rdata;
    fills = fill_cnt - f0;
  endtask

  task automatic check_read(input logic [31:0] a, input string req, input bit exp_hit);
    logic [31:0] got;
    int lat, fills;
    do_read(a, got, lat, fills);
    chk(got == arch[int'(a[13:2])], req, "read data", got, arch[int'(a[13:2])]);
    if (exp_hit) begin
      chk(lat == 1 && fills == 0, req, "hit latency/no fill", 32'(lat*16 + fills), 32'h10);
    end else begin
      chk(fills == 1, req, "miss fill count", 32'(fills), 32'd1);
      chk(last_fill_addr == {a[31:6], 6'b0}, req, "fill line address",
          last_fill_addr, {a[31:6], 6'b0});
    end
  endtask

  task automatic do_write(input logic [31:0] a, input logic [31:0] d);
    logic rdy;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    do begin
      #1 rdy = req_ready;
      @(posedge clk);
    end while (!rdy);
    arch[int'(a[13:2])] = d;
    exp_q.push_back({a[31:2], 2'b00, d});
    stores++;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog expired act=%0d exp=%0d", total, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] got;
    int lat, fills, f0;
    for (int i = 0; i < MEM_WORDS; i++) begin
      arch[i]   = 32'(i) * 32'h9E3779B1 ^ 32'h1357_0000;
      nl_mem[i] = arch[i];
    end

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 32'd1);
    chk(resp_valid == 1'b0, "R1", "no response", 32'(resp_valid), 32'd0);
    chk(fill_req_valid == 1'b0, "R1", "no line request", 32'(fill_req_valid), 32'd0);
    chk(wr_valid == 1'b0, "R1", "no downstream write", 32'(wr_valid), 32'd0);

    // R3/R2/R11 sweep: fill every index, then read every word back as a hit
    for (int idx = 0; idx < 16; idx++) begin
      check_read(32'(idx*64 + (idx%16)*4 + (idx%4)), "R3", 1'b0);
      for (int w = 0; w < 16; w++) check_read(32'(idx*64 + w*4), "R2", 1'b1);
    end

    // R11 conflict: same index, different tag evicts; other index survives
    check_read(32'h0000_0400, "R11", 1'b0);
    check_read(32'h0000_0000, "R11", 1'b0);
    check_read(32'h0000_0044, "R11", 1'b1);

    // R5 store hits across a whole line
    for (int w = 0; w < 16; w++) do_write(32'(3*64 + w*4), 32'hA500_0000 + 32'(w));
    for (int w = 0; w < 16; w++) check_read(32'(3*64 + w*4), "R5", 1'b1);

    // R6 store miss: no fill, resident line intact, later read misses with new data
    f0 = fill_cnt;
    do_write(32'h0000_2008, 32'hDEAD_0006);
    repeat (4) @(negedge clk);
    chk(fill_cnt == f0, "R6", "no fill for store miss", 32'(fill_cnt - f0), 32'd0);
    check_read(32'h0000_0000, "R6", 1'b1);
    check_read(32'h0000_2008, "R6", 1'b0);

    // R7 buffer capacity with a stalled downstream port
    wr_stall = 1'b1;
    for (int k = 0; k < 4; k++) do_write(32'h0000_3000 + 32'(k*4), 32'hB700_0000 + 32'(k));
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 32'h0000_3010; req_wdata = 32'hFFFF_FFFF;
    repeat (3) begin
      #1 chk(req_ready == 1'b0, "R7", "write refused when full", 32'(req_ready), 32'd0);
      @(negedge clk);
    end
    req_valid = 1'b0; req_write = 1'b0;
    chk(wr_valid == 1'b1, "R7", "writes still pending", 32'(wr_valid), 32'd1);
    check_read(32'h0000_0048, "R7", 1'b1);

    // R8 read miss on a line with pending writes waits for the drain
    f0 = fill_cnt;
    fork
      begin
        do_read(32'h0000_3004, got, lat, fills);
      end
      begin
        repeat (20) @(negedge clk);
        chk(fill_req_valid == 1'b0, "R8", "no line request while pending",
            32'(fill_req_valid), 32'd0);
        chk(fill_cnt == f0, "R8", "no fill while pending", 32'(fill_cnt - f0), 32'd0);
        wr_stall = 1'b0;
      end
    join
    chk(got == arch[int'(32'h3004 >> 2)], "R8", "fill sees drained data",
        got, arch[int'(32'h3004 >> 2)]);
    chk(fills == 1, "R8", "one fill after drain", 32'(fills), 32'd1);
    check_read(32'h0000_3000, "R8", 1'b1);

    // R9 unrelated miss proceeds while the write port stays stalled
    wr_stall = 1'b1;
    do_write(32'h0000_3400, 32'hC900_0009);
    do_read(32'h0000_0500, got, lat, fills);
    chk(lat < 200 && fills == 1, "R9", "miss served during stall", 32'(lat), 32'd30);
    chk(got == arch[int'(32'h0500 >> 2)], "R9", "read data", got, arch[int'(32'h0500 >> 2)]);
    chk(wr_valid == 1'b1, "R9", "write still held", 32'(wr_valid), 32'd1);
    wr_stall = 1'b0;

    // R10 no write-back traffic beyond the stores themselves
    repeat (30) @(negedge clk);
    chk(dwr_cnt == stores, "R10", "downstream write count", 32'(dwr_cnt), 32'(stores));
    chk(exp_q.size() == 0, "R10", "all stores drained", 32'(exp_q.size()), 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule